// File: doc/BRIEF.md
# Ordered Dial Combination Lock

This block is a synchronous finite state machine for a dial lock that opens only when three dial operations arrive in one fixed order. Each operation is a turn direction plus a dial number, offered for one cycle with a valid strobe. The combination is right to 13, then left to 22, then right to 3. Only this order opens the lock. The same three numbers in another order, or with a different direction, leave it shut.

The machine has four states, held in a two-bit register: idle locked, first step done, second step done, and open. The open output is a Moore output and depends only on the state. An operation outside the combination sends the machine back to idle. A right-13 is always counted as a fresh first step. While open, the next valid operation relocks the lock, and that operation is then judged as if the machine were idle. A synchronous reset returns the lock to idle.

Top module: `combo_lock_fsm`

## Requirements
- R1: A synchronous active-high reset puts the machine in the idle locked state (encoding 00). `unlocked` is low after the reset edge.
- R2: The valid operations right-13, left-22, right-3, in that order, raise `unlocked` in the cycle after the clock edge that samples the third one.
- R3: In a cycle where `op_valid` is low, the state does not change, whatever the values of the direction and dial inputs. Gaps between steps are allowed, and an open lock stays open.
- R4: A valid operation that does not match the next expected step, and is not right-13, returns the machine to idle. The full combination is then needed again.
- R5: The direction is part of each step (`op_right` = 1 means right, 0 means left). The correct numbers with a wrong direction do not advance the machine.
- R6: A valid right-13 moves the machine to the first-step state (01) from any state, including the first-step state (01) and the second-step state (10).
- R7: In the open state (11), any valid operation relocks the lock and is evaluated as if the machine were idle. A right-13 then leaves it in the first-step state, and a right-3 leaves it idle.
- R8: `unlocked` is high only in the open state. It can rise only on an edge that leaves the second-step state (10).
- R9: Reset takes priority over a valid operation sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe marking a dial operation |
| op_right | input | 1 | Turn direction: 1 = right, 0 = left |
| op_dial | input | 6 | Dial number, 0 to 39 |
| unlocked | output | 1 | High while the lock is open |

## Verification
The bench checks that the right values in the wrong order, or with a flipped direction, leave the lock shut. A design that compared values without order or direction would open on those sequences. Repeated right-13 operations in the first-step and second-step states must still open the lock when the rest of the combination follows. A design that reset to idle on them would stay shut. Operations in the open state must relock the lock and then count as a fresh start. Idle cycles with random-looking inputs must leave progress untouched, and a reset that coincides with a valid step must win. A design that let the step through would open one operation early.

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm #(
  parameter int DIAL_W  = 6,
  parameter int NUM_1ST = 13,
  parameter int NUM_2ND = 22,
  parameter int NUM_3RD = 3,
  parameter bit DIR_1ST = 1'b1,
  parameter bit DIR_2ND = 1'b0,
  parameter bit DIR_3RD = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_right,
  input  logic [DIAL_W-1:0] op_dial,
  output logic              unlocked
);

  localparam logic [1:0] ST_IDLE = 2'b00;
  localparam logic [1:0] ST_ONE  = 2'b01;
  localparam logic [1:0] ST_TWO  = 2'b10;
  localparam logic [1:0] ST_OPEN = 2'b11;

  localparam logic [DIAL_W-1:0] K1 = DIAL_W'(NUM_1ST);
  localparam logic [DIAL_W-1:0] K2 = DIAL_W'(NUM_2ND);
  localparam logic [DIAL_W-1:0] K3 = DIAL_W'(NUM_3RD);

  logic [1:0] state, base, nxt;
  logic hit1, hit2, hit3;

  assign hit1 = (op_right == DIR_1ST) && (op_dial == K1);
  assign hit2 = (op_right == DIR_2ND) && (op_dial == K2);
  assign hit3 = (op_right == DIR_3RD) && (op_dial == K3);

  assign base = (state == ST_OPEN) ? ST_IDLE : state;

  always_comb begin
    nxt = state;
    if (op_valid) begin
      if (hit1)                          nxt = ST_ONE;
      else if (base == ST_ONE && hit2)   nxt = ST_TWO;
      else if (base == ST_TWO && hit3)   nxt = ST_OPEN;
      else                               nxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  assign unlocked = (state == ST_OPEN);

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (state == ST_IDLE && !unlocked));

  p_third_opens_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TWO && op_valid && op_right == DIR_3RD && op_dial == K3) |=> unlocked);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(state));

  p_wrong_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !hit1 && !hit2 && !hit3) |=> (state == ST_IDLE));

  p_restart_one_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_right == DIR_1ST && op_dial == K1) |=> (state == ST_ONE));

  p_open_relock_r7: assert property (@(posedge clk) disable iff (rst)
    (unlocked && op_valid) |=> !unlocked);

  p_open_from_two_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(state) == ST_TWO));

endmodule

// File: tb/tb_combo_lock_fsm.sv
module tb_combo_lock_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic op_right = 1'b0;
  logic [5:0] op_dial = '0;
  logic unlocked;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  combo_lock_fsm dut (
    .clk(clk), .rst(rst), .op_valid(op_valid),
    .op_right(op_right), .op_dial(op_dial), .unlocked(unlocked)
  );

  task automatic check(input logic exp, input string tag);
    n_checks++;
    if (unlocked !== exp) begin
      n_fail++;
      $display("FAIL %s: unlocked=%b expected=%b", tag, unlocked, exp);
    end
  endtask

  task automatic op(input logic right, input int dial);
    op_valid = 1'b1; op_right = right; op_dial = 6'(dial);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      op_right = i[0]; op_dial = 6'(i * 7 + 3);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(1'b0, "R1 reset locked");
  endtask

  task automatic t_basic_open();
    do_reset();
    op(1, 13); check(1'b0, "R2 after step1");
    op(0, 22); check(1'b0, "R2 after step2");
    op(1, 3);  check(1'b1, "R2 opens after step3");
  endtask

  task automatic t_gaps();
    do_reset();
    op(1, 13); idle(3);
    op(0, 22); idle(2);
    op(1, 3);  check(1'b1, "R3 gaps keep progress");
    idle(5);   check(1'b1, "R3 open held without valid");
  endtask

  task automatic t_wrong();
    do_reset();
    op(1, 13); op(0, 22); op(0, 3);
    check(1'b0, "R4 wrong third step");
    op(1, 3);  check(1'b0, "R4 progress lost");
    op(1, 13); op(0, 5); op(0, 22); op(1, 3);
    check(1'b0, "R4 wrong middle step");
    op(0, 22); op(1, 3); check(1'b0, "R4 order matters");
  endtask

  task automatic t_direction();
    do_reset();
    op(0, 13); op(0, 22); op(1, 3);
    check(1'b0, "R5 left13 first");
    op(1, 13); op(1, 22); op(1, 3);
    check(1'b0, "R5 right22 second");
    op(1, 13); op(0, 22); op(0, 3);
    check(1'b0, "R5 left3 third");
  endtask

  task automatic t_restart();
    do_reset();
    op(1, 13); op(1, 13); op(0, 22); op(1, 3);
    check(1'b1, "R6 repeat right13 in step1 state");
    do_reset();
    op(1, 13); op(0, 22); op(1, 13); op(0, 22); op(1, 3);
    check(1'b1, "R6 right13 in step2 state restarts");
  endtask

  task automatic t_open_relock();
    do_reset();
    op(1, 13); op(0, 22); op(1, 3);
    check(1'b1, "R8 open in final state");
    op(1, 13); check(1'b0, "R7 relock on right13");
    op(0, 22); op(1, 3); check(1'b1, "R7 right13 counted as step1");
    op(1, 3);  check(1'b0, "R7 relock on right3");
    op(0, 22); op(1, 3); check(1'b0, "R7 evaluated from idle");
  endtask

  task automatic t_reset_priority();
    do_reset();
    op(1, 13); op(0, 22);
    rst = 1'b1; op(1, 3); rst = 1'b0;
    check(1'b0, "R9 reset beats third step");
    op(1, 3); check(1'b0, "R9 progress cleared by reset");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic_open();
    t_gaps();
    t_wrong();
    t_direction();
    t_restart();
    t_open_relock();
    t_reset_priority();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule